// File: doc/BRIEF.md
# Single-Bit Set/Clear/Test Execution Unit

This unit carries out the bit-level instructions of a small 4-bit controller. It takes an instruction of one or two bytes together with the current HL pointer, LR register and accumulator. It then sets, clears or tests one bit of a 4-bit nibble. The nibble can sit in the accumulator, in RAM or in an I/O port. RAM is addressed directly or through HL. Ports are addressed directly or through LR, where LR[3:2]+4 picks the port and LR[1:0] picks the bit. Set and clear work as read-modify-write cycles on an asynchronous-read RAM interface and an asynchronous-read port interface. Tests place their result in a status flag.

The surrounding core pulses `start_i` with both opcode bytes valid. Forms that address through HL or the accumulator finish in the issue cycle. Forms with a direct address or an LR-indirect port take a second cycle, and `busy_o` is high during that cycle. An opcode outside the group raises `illegal_o` and does nothing else.

Top module: `bm_exec_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `sf_o` is 0 and `busy_o`, `done_o`, `illegal_o`, `mem_wr_en_o` and `prt_wr_en_o` are all 0.
- R2: A first byte of the form 1111_ccbb is a one-cycle instruction with bit index bb. cc=00 clears bit bb of RAM[HL]. cc=01 sets it. cc=10 tests bit bb of the accumulator for false. cc=11 tests bit bb of RAM[HL] for false. `done_o` is high in the issue cycle.
- R3: First byte 0110_1100 with second byte ccbb_aaaa works on RAM at address aaaa, zero-extended. cc=00 tests false, 01 sets, 10 tests true and 11 clears bit bb.
- R4: First byte 0110_1101 with second byte ccbb_pppp works on port pppp, with the same cc meanings as R3.
- R5: One-byte opcodes 0110_0000, 0110_0001 and 0110_0010 clear, test false and set, respectively, bit LR[1:0] of port LR[3:2]+4. The LR value is taken in the issue cycle.
- R6: A set or clear writes back the nibble with only the addressed bit changed, and `sf_o` becomes 1 from the next clock.
- R7: A test-false loads `sf_o` with the inverse of the addressed bit, and a test-true loads it with the bit itself. A test writes nothing.
- R8: The forms in R3, R4 and R5 take two cycles. `busy_o` and `done_o` are high in the second cycle, the access happens in that cycle, and a `start_i` arriving in that cycle is ignored.
- R9: Any other opcode raises `illegal_o` in its issue cycle. It writes no RAM or port and leaves `sf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Issue pulse, opcode bytes valid |
| op_b0_i | input | 8 | First opcode byte |
| op_b1_i | input | 8 | Second opcode byte (two-byte forms) |
| hl_i | input | RAM_AW | HL pointer |
| lr_i | input | 4 | LR register |
| acc_i | input | 4 | Accumulator value |
| busy_o | output | 1 | Second cycle of a two-cycle form |
| done_o | output | 1 | Access cycle of an instruction |
| illegal_o | output | 1 | Issued opcode is outside the group |
| sf_o | output | 1 | Status flag |
| mem_rd_en_o | output | 1 | RAM read strobe |
| mem_wr_en_o | output | 1 | RAM write strobe |
| mem_addr_o | output | RAM_AW | RAM nibble address |
| mem_wdata_o | output | 4 | RAM write data |
| mem_rdata_i | input | 4 | RAM read data (same cycle) |
| prt_rd_en_o | output | 1 | Port read strobe |
| prt_wr_en_o | output | 1 | Port write strobe |
| prt_addr_o | output | PORT_AW | Port number |
| prt_wdata_o | output | 4 | Port write data |
| prt_rdata_i | input | 4 | Port read data (same cycle) |

## Verification
A one-cycle form raises `done_o` and drives its write strobe during the issue cycle. Its flag appears on `sf_o` after the next rising edge. A two-cycle form shows `busy_o` and its access one cycle later, and its flag appears after the edge that ends that second cycle. The bench drives each instruction at a falling edge and samples 1 ns later. Its model updates the expected flag and nibbles at exactly the edge the unit should act on, and it compares `sf_o` at every falling edge. The RAM and port images are compared once each instruction has completed.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int NIB_W = 4;
    localparam int BIX_W = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_TSTF,
        OP_TSTT
    } bop_e;

    typedef enum logic [1:0] {
        TG_ACC,
        TG_RAM,
        TG_PORT
    } tgt_e;

    typedef struct packed {
        bop_e             op;
        tgt_e             tgt;
        logic [BIX_W-1:0] bidx;
        logic             slow;
        logic             legal;
    } bdec_t;
endpackage

// File: rtl/bm_decode.sv
module bm_decode import bm_pkg::*; #(
    parameter int RAM_AW  = 8,
    parameter int PORT_AW = 4
) (
    input  logic [7:0]         b0_i,
    input  logic [7:0]         b1_i,
    input  logic [RAM_AW-1:0]  hl_i,
    input  logic [NIB_W-1:0]   lr_i,
    output bdec_t              dec_o,
    output logic [RAM_AW-1:0]  ram_a_o,
    output logic [PORT_AW-1:0] prt_a_o
);
    // op code for the two-byte forms, indexed by the high two bits of byte 1
    function automatic bop_e wide_op(input logic [1:0] c);
        case (c)
            2'b00:   return OP_TSTF;
            2'b01:   return OP_SET;
            2'b10:   return OP_TSTT;
            default: return OP_CLR;
        endcase
    endfunction

    always_comb begin
        dec_o   = '{op: OP_NONE, tgt: TG_ACC, bidx: '0, slow: 1'b0, legal: 1'b0};
        ram_a_o = hl_i;
        prt_a_o = '0;
        if (b0_i[7:4] == 4'hF) begin
            dec_o.legal = 1'b1;
            dec_o.bidx  = b0_i[1:0];
            case (b0_i[3:2])
                2'b00:   begin dec_o.op = OP_CLR;  dec_o.tgt = TG_RAM; end
                2'b01:   begin dec_o.op = OP_SET;  dec_o.tgt = TG_RAM; end
                2'b10:   begin dec_o.op = OP_TSTF; dec_o.tgt = TG_ACC; end
                default: begin dec_o.op = OP_TSTF; dec_o.tgt = TG_RAM; end
            endcase
        end else if (b0_i[7:1] == 7'b0110_110) begin
            dec_o.legal = 1'b1;
            dec_o.slow  = 1'b1;
            dec_o.bidx  = b1_i[5:4];
            dec_o.op    = wide_op(b1_i[7:6]);
            dec_o.tgt   = b0_i[0] ? TG_PORT : TG_RAM;
            ram_a_o     = RAM_AW'(b1_i[3:0]);
            prt_a_o     = PORT_AW'(b1_i[3:0]);
        end else if (b0_i[7:2] == 6'b0110_00 && b0_i[1:0] != 2'b11) begin
            dec_o.legal = 1'b1;
            dec_o.slow  = 1'b1;
            dec_o.tgt   = TG_PORT;
            dec_o.bidx  = lr_i[1:0];
            prt_a_o     = PORT_AW'({1'b0, lr_i[3:2]} + 3'd4);
            case (b0_i[1:0])
                2'b00:   dec_o.op = OP_CLR;
                2'b01:   dec_o.op = OP_TSTF;
                default: dec_o.op = OP_SET;
            endcase
        end
    end
endmodule

// File: rtl/bm_bitop.sv
module bm_bitop import bm_pkg::*; (
    input  bop_e             op_i,
    input  logic [BIX_W-1:0] bidx_i,
    input  logic [NIB_W-1:0] rd_i,
    output logic [NIB_W-1:0] wd_o,
    output logic             wr_o,
    output logic             sf_o,
    output logic             sf_ld_o
);
    logic [NIB_W-1:0] mask;
    logic             sel_bit;

    assign mask    = NIB_W'(1) << bidx_i;
    assign sel_bit = rd_i[bidx_i];

    always_comb begin
        wd_o    = rd_i;
        wr_o    = 1'b0;
        sf_o    = 1'b0;
        sf_ld_o = 1'b0;
        case (op_i)
            OP_SET:  begin wd_o = rd_i | mask;  wr_o = 1'b1; sf_o = 1'b1; sf_ld_o = 1'b1; end
            OP_CLR:  begin wd_o = rd_i & ~mask; wr_o = 1'b1; sf_o = 1'b1; sf_ld_o = 1'b1; end
            OP_TSTF: begin sf_o = ~sel_bit; sf_ld_o = 1'b1; end
            OP_TSTT: begin sf_o = sel_bit;  sf_ld_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/bm_exec_unit.sv
module bm_exec_unit import bm_pkg::*; #(
    parameter int RAM_AW  = 8,
    parameter int PORT_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [7:0]         op_b0_i,
    input  logic [7:0]         op_b1_i,
    input  logic [RAM_AW-1:0]  hl_i,
    input  logic [NIB_W-1:0]   lr_i,
    input  logic [NIB_W-1:0]   acc_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               illegal_o,
    output logic               sf_o,
    output logic               mem_rd_en_o,
    output logic               mem_wr_en_o,
    output logic [RAM_AW-1:0]  mem_addr_o,
    output logic [NIB_W-1:0]   mem_wdata_o,
    input  logic [NIB_W-1:0]   mem_rdata_i,
    output logic               prt_rd_en_o,
    output logic               prt_wr_en_o,
    output logic [PORT_AW-1:0] prt_addr_o,
    output logic [NIB_W-1:0]   prt_wdata_o,
    input  logic [NIB_W-1:0]   prt_rdata_i
);
    typedef struct packed {
        logic               busy;
        bop_e               op;
        tgt_e               tgt;
        logic [BIX_W-1:0]   bidx;
        logic [RAM_AW-1:0]  ra;
        logic [PORT_AW-1:0] pa;
        logic               sf;
    } st_t;

    st_t st_d, st_q;

    bdec_t              dec;
    logic [RAM_AW-1:0]  dec_ra;
    logic [PORT_AW-1:0] dec_pa;

    bm_decode #(.RAM_AW(RAM_AW), .PORT_AW(PORT_AW)) u_dec (
        .b0_i    (op_b0_i),
        .b1_i    (op_b1_i),
        .hl_i    (hl_i),
        .lr_i    (lr_i),
        .dec_o   (dec),
        .ram_a_o (dec_ra),
        .prt_a_o (dec_pa)
    );

    // issue acceptance and the operation acting in this cycle
    logic               take, act;
    bop_e               a_op, eff_op;
    tgt_e               a_tgt;
    logic [BIX_W-1:0]   a_bidx;
    logic [NIB_W-1:0]   a_rd, a_wd;
    logic               a_wr, a_sf, a_sf_ld;

    assign take   = !st_q.busy && start_i && dec.legal;
    assign act    = st_q.busy || (take && !dec.slow);
    assign a_op   = st_q.busy ? st_q.op   : dec.op;
    assign a_tgt  = st_q.busy ? st_q.tgt  : dec.tgt;
    assign a_bidx = st_q.busy ? st_q.bidx : dec.bidx;
    assign eff_op = act ? a_op : OP_NONE;

    always_comb begin
        case (a_tgt)
            TG_RAM:  a_rd = mem_rdata_i;
            TG_PORT: a_rd = prt_rdata_i;
            default: a_rd = acc_i;
        endcase
    end

    bm_bitop u_bit (
        .op_i    (eff_op),
        .bidx_i  (a_bidx),
        .rd_i    (a_rd),
        .wd_o    (a_wd),
        .wr_o    (a_wr),
        .sf_o    (a_sf),
        .sf_ld_o (a_sf_ld)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
        end else if (take && dec.slow) begin
            st_d.busy = 1'b1;
            st_d.op   = dec.op;
            st_d.tgt  = dec.tgt;
            st_d.bidx = dec.bidx;
            st_d.ra   = dec_ra;
            st_d.pa   = dec_pa;
        end
        if (a_sf_ld) begin
            st_d.sf = a_sf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_t'('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign done_o      = act;
    assign illegal_o   = !st_q.busy && start_i && !dec.legal;
    assign sf_o        = st_q.sf;
    assign mem_addr_o  = st_q.busy ? st_q.ra : dec_ra;
    assign prt_addr_o  = st_q.busy ? st_q.pa : dec_pa;
    assign mem_rd_en_o = act && (a_tgt == TG_RAM);
    assign prt_rd_en_o = act && (a_tgt == TG_PORT);
    assign mem_wr_en_o = a_wr && (a_tgt == TG_RAM);
    assign prt_wr_en_o = a_wr && (a_tgt == TG_PORT);
    assign mem_wdata_o = a_wd;
    assign prt_wdata_o = a_wd;
endmodule

// File: rtl/bm_exec_sva.sv
module bm_exec_sva import bm_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             illegal_o,
    input logic             sf_o,
    input logic             mem_wr_en_o,
    input logic             prt_wr_en_o,
    input logic [NIB_W-1:0] mem_rdata_i,
    input logic [NIB_W-1:0] mem_wdata_o,
    input logic [NIB_W-1:0] prt_rdata_i,
    input logic [NIB_W-1:0] prt_wdata_o
);
    AST_RAM_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> $countones(mem_wdata_o ^ mem_rdata_i) <= 1); // R6
    AST_PORT_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prt_wr_en_o |-> $countones(prt_wdata_o ^ prt_rdata_i) <= 1); // R6
    AST_WRITE_RAISES_SF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en_o || prt_wr_en_o) |=> sf_o); // R6
    AST_SINGLE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en_o && prt_wr_en_o)); // R6
    AST_WRITE_IN_DONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en_o || prt_wr_en_o) |-> done_o); // R8
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R8
    AST_BUSY_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> done_o && !illegal_o); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_wr_en_o && !prt_wr_en_o && !done_o); // R9
    AST_ILLEGAL_SF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable(sf_o)); // R9
    AST_ILLEGAL_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> start_i); // R9
endmodule

bind bm_exec_unit bm_exec_sva i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .sf_o        (sf_o),
    .mem_wr_en_o (mem_wr_en_o),
    .prt_wr_en_o (prt_wr_en_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_wdata_o (mem_wdata_o),
    .prt_rdata_i (prt_rdata_i),
    .prt_wdata_o (prt_wdata_o)
);

// File: tb/test_bm_exec_unit.sv
`timescale 1ns/100ps
module test_bm_exec_unit;
    localparam int RAM_AW  = 8;
    localparam int PORT_AW = 4;
    localparam int RAM_N   = 1 << RAM_AW;
    localparam int PORT_N  = 1 << PORT_AW;
    localparam int K_NONE = 0, K_SET = 1, K_CLR = 2, K_TF = 3, K_TT = 4;
    localparam int T_ACC = 0, T_RAM = 1, T_PORT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] b0 = '0, b1 = '0;
    logic [RAM_AW-1:0] hl = '0;
    logic [3:0] lr = '0, acc = '0;

    logic busy, done, illegal, sf;
    logic mem_rd, mem_wr, prt_rd, prt_wr;
    logic [RAM_AW-1:0] mem_addr;
    logic [PORT_AW-1:0] prt_addr;
    logic [3:0] mem_wdata, mem_rdata, prt_wdata, prt_rdata;

    logic [3:0] ram [RAM_N];
    logic [3:0] prt [PORT_N];
    logic [3:0] mdl_ram [RAM_N];
    logic [3:0] mdl_prt [PORT_N];
    logic exp_sf = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bm_exec_unit #(.RAM_AW(RAM_AW), .PORT_AW(PORT_AW)) i_bm_exec_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_b0_i(b0), .op_b1_i(b1),
        .hl_i(hl), .lr_i(lr), .acc_i(acc),
        .busy_o(busy), .done_o(done), .illegal_o(illegal), .sf_o(sf),
        .mem_rd_en_o(mem_rd), .mem_wr_en_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .prt_rd_en_o(prt_rd), .prt_wr_en_o(prt_wr), .prt_addr_o(prt_addr),
        .prt_wdata_o(prt_wdata), .prt_rdata_i(prt_rdata)
    );

    assign mem_rdata = ram[mem_addr];
    assign prt_rdata = prt[prt_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_N; i++) ram[i] <= 4'(i * 7 + 3);
            for (int i = 0; i < PORT_N; i++) prt[i] <= 4'(i * 5 + 9);
        end else begin
            if (mem_wr) ram[mem_addr] <= mem_wdata;
            if (prt_wr) prt[prt_addr] <= prt_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-clock flag comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) chk(sf === exp_sf, "R7 per-clock SF", int'(sf), int'(exp_sf));
    end

    task automatic model_decode(input logic [7:0] c0, input logic [7:0] c1,
                                output bit legal, output bit slow, output int kind,
                                output int tgt, output int a, output int b);
        legal = 1; slow = 0; kind = K_NONE; tgt = T_ACC; a = 0; b = 0;
        if (c0[7:4] == 4'hF) begin
            b = int'(c0[1:0]); a = int'(hl);
            case (c0[3:2])
                2'd0: begin kind = K_CLR; tgt = T_RAM; end
                2'd1: begin kind = K_SET; tgt = T_RAM; end
                2'd2: begin kind = K_TF;  tgt = T_ACC; end
                default: begin kind = K_TF; tgt = T_RAM; end
            endcase
        end else if (c0 == 8'h6C || c0 == 8'h6D) begin
            slow = 1; b = int'(c1[5:4]); a = int'(c1[3:0]);
            tgt = (c0 == 8'h6C) ? T_RAM : T_PORT;
            case (c1[7:6])
                2'd0: kind = K_TF;
                2'd1: kind = K_SET;
                2'd2: kind = K_TT;
                default: kind = K_CLR;
            endcase
        end else if (c0 == 8'h60 || c0 == 8'h61 || c0 == 8'h62) begin
            slow = 1; tgt = T_PORT; a = int'(lr[3:2]) + 4; b = int'(lr[1:0]);
            kind = (c0 == 8'h60) ? K_CLR : (c0 == 8'h61) ? K_TF : K_SET;
        end else begin
            legal = 0;
        end
    endtask

    task automatic model_apply(input int kind, input int tgt, input int a, input int b);
        logic [3:0] v;
        v = (tgt == T_RAM) ? mdl_ram[a] : (tgt == T_PORT) ? mdl_prt[a] : acc;
        case (kind)
            K_SET: begin v[b] = 1'b1; exp_sf = 1'b1; end
            K_CLR: begin v[b] = 1'b0; exp_sf = 1'b1; end
            K_TF:  exp_sf = ~v[b];
            K_TT:  exp_sf = v[b];
            default: ;
        endcase
        if (tgt == T_RAM) mdl_ram[a] = v;
        if (tgt == T_PORT) mdl_prt[a] = v;
    endtask

    task automatic cmp_images(input string req);
        int bad = 0;
        for (int i = 0; i < RAM_N; i++) if (ram[i] !== mdl_ram[i]) bad++;
        for (int i = 0; i < PORT_N; i++) if (prt[i] !== mdl_prt[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run(input logic [7:0] c0, input logic [7:0] c1, input bit poke, input string req);
        bit legal, slow;
        int kind, tgt, a, b;
        model_decode(c0, c1, legal, slow, kind, tgt, a, b);
        @(negedge clk);
        b0 = c0; b1 = c1; start = 1'b1;
        #1;
        chk(illegal === !legal, {req, " R9 illegal flag at issue"}, int'(illegal), int'(!legal));
        chk(done === (legal && !slow), {req, " R8 done at issue"}, int'(done), int'(legal && !slow));
        @(posedge clk);
        if (legal && !slow) model_apply(kind, tgt, a, b);
        @(negedge clk);
        if (poke && slow) begin b0 = 8'hF4; b1 = 8'h00; start = 1'b1; end
        else start = 1'b0;
        if (slow) begin
            #1;
            chk(busy === 1'b1, {req, " R8 busy in second cycle"}, int'(busy), 1);
            chk(done === 1'b1, {req, " R8 done in second cycle"}, int'(done), 1);
            @(posedge clk);
            if (legal) model_apply(kind, tgt, a, b);
            @(negedge clk);
            start = 1'b0;
        end
        #1;
        chk(sf === exp_sf, {req, " SF result"}, int'(sf), int'(exp_sf));
        chk(busy === 1'b0, {req, " R8 idle after completion"}, int'(busy), 0);
        cmp_images({req, " R6 RAM/port images"});
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog: actual 1 expected 0 (run hung)");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < RAM_N; i++) mdl_ram[i] = 4'(i * 7 + 3);
        for (int i = 0; i < PORT_N; i++) mdl_prt[i] = 4'(i * 5 + 9);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(sf === 1'b0, "R1 reset SF", int'(sf), 0);
        chk(busy === 1'b0 && done === 1'b0 && illegal === 1'b0, "R1 reset status",
            int'({busy, done, illegal}), 0);
        chk(mem_wr === 1'b0 && prt_wr === 1'b0, "R1 reset no write", int'({mem_wr, prt_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(sf === 1'b0 && busy === 1'b0, "R1 first cycle after reset", int'({sf, busy}), 0);

        // R2 one-byte HL and accumulator forms
        hl = 8'h05; acc = 4'b1010;
        run(8'hF4, 8'h00, 0, "R2 set RAM[HL] bit0");
        run(8'hF1, 8'h00, 0, "R2 clear RAM[HL] bit1");
        run(8'hF8, 8'h00, 0, "R2 R7 test-false acc bit0");
        run(8'hF9, 8'h00, 0, "R2 R7 test-false acc bit1");
        run(8'hFE, 8'h00, 0, "R2 R7 test-false RAM[HL] bit2");

        // R3 direct RAM forms
        run(8'h6C, {2'b01, 2'd3, 4'hA}, 0, "R3 set RAM[A] bit3 already set");
        run(8'h6C, {2'b11, 2'd0, 4'hA}, 0, "R3 clear RAM[A] bit0");
        run(8'h6C, {2'b10, 2'd3, 4'hA}, 0, "R3 R7 test-true RAM[A] bit3");
        run(8'h6C, {2'b00, 2'd1, 4'h3}, 0, "R3 R7 test-false RAM[3] bit1");

        // R4 direct port forms
        run(8'h6D, {2'b01, 2'd2, 4'h2}, 0, "R4 set port2 bit2");
        run(8'h6D, {2'b11, 2'd0, 4'h2}, 0, "R4 clear port2 bit0");
        run(8'h6D, {2'b10, 2'd1, 4'h2}, 0, "R4 R7 test-true port2 bit1");
        run(8'h6D, {2'b00, 2'd0, 4'h9}, 0, "R4 R7 test-false port9 bit0");

        // R5 LR-indirect port forms
        lr = 4'b0110;
        run(8'h62, 8'h00, 0, "R5 set port5 bit2");
        lr = 4'b1111;
        run(8'h60, 8'h00, 0, "R5 clear port7 bit3");
        run(8'h61, 8'h00, 0, "R5 R7 test-false port7 bit3");
        lr = 4'b0000;
        run(8'h61, 8'h00, 0, "R5 R7 test-false port4 bit0");

        // R9 opcodes outside the group
        run(8'h63, 8'h00, 0, "R9 opcode 63");
        run(8'h6E, 8'h4A, 0, "R9 opcode 6E");
        run(8'h00, 8'h00, 0, "R9 opcode 00");
        run(8'h6F, 8'hFF, 0, "R9 opcode 6F");
        run(8'hE3, 8'h00, 0, "R9 opcode E3");
        run(8'hF4, 8'h00, 0, "R6 set again before illegal");
        run(8'h70, 8'h00, 0, "R9 opcode 70 keeps SF=1");

        // R8 issue during the busy cycle is ignored: RAM[1] bit0 must stay clear
        hl = 8'h01;
        run(8'h6C, {2'b00, 2'd2, 4'hB}, 1, "R8 start ignored while busy");

        summary();
    end
endmodule